// File: doc/BRIEF.md
# UART Interrupt Enable, Mask and Status Bank

This block holds the interrupt control state of a serial port. Software never writes the mask directly. It writes ones to an enable register to turn mask bits on, and ones to a disable register to turn them off. Event pulses from the receiver and transmitter land in a sticky status register whether or not they are masked. Software clears status bits by writing ones back to them.

A single interrupt line is raised when at least one status bit is set and also unmasked. A separate channel-status view shows the live FIFO level conditions, which do not depend on the mask. All registers sit behind a plain word-wide read/write port. Read data is registered and is valid in the cycle after the read strobe.

Top module: `uart_irq_bank`

## Requirements
- R1: A synchronous reset clears the mask, the status register, `irq` and `rd_data` to zero.
- R2: Writing to offset 0x08 (enable) sets each mask bit whose write-data bit is 1. Bits written as 0, and write-data bits at or above position NUM_EVT, change nothing.
- R3: Writing to offset 0x0C (disable) clears each mask bit whose write-data bit is 1. Bits written as 0 change nothing.
- R4: Read data appears on `rd_data` in the cycle after `rd_en`. Reads of offsets 0x08 and 0x0C return 0.
- R5: Writes to offset 0x10 (mask, read-only) leave the mask unchanged. Writes to offset 0x2C (channel status) leave both the mask and the status register unchanged.
- R6: A high cycle on `evt_in[i]` sets status bit i at offset 0x14, whether or not bit i is masked. The bit stays set until it is cleared. The bit positions are: 8 receive timeout, 7 parity error, 6 framing error, 5 overrun, 4 TX full, 3 TX empty, 2 RX full, 1 RX empty, 0 RX trigger.
- R7: Writing ones to offset 0x14 clears those status bits. Bits written as 0 keep their value.
- R8: If an event pulse and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high in the cycle after any bit is set in both the status and the mask. Otherwise it is low.
- R10: A read of offset 0x2C returns the live `lvl_in` levels at bits 0 (RX trigger), 1 (RX empty), 3 (TX empty) and 4 (TX full). All other bits read 0, and the mask has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, valid in the cycle after rd_en |
| evt_in | input | NUM_EVT | Single-cycle event pulses from the receiver and transmitter |
| lvl_in | input | NUM_EVT | Live condition levels shown in channel status |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together, and that each write strobe lasts one cycle and carries one offset. The stimulus enforces this: each access lives in its own task that drives one strobe for one cycle at the falling edge. Event pulses are also driven at the falling edge, held for one cycle, then returned to zero. Every sampled input is therefore stable across the rising edge. The only deliberate overlap is an event pulse coinciding with a status clear, which exercises the set-wins rule.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned OFF_ENABLE  = 'h08;
  localparam int unsigned OFF_DISABLE = 'h0C;
  localparam int unsigned OFF_MASK    = 'h10;
  localparam int unsigned OFF_STATUS  = 'h14;
  localparam int unsigned OFF_CHAN    = 'h2C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_DISABLE,
    SEL_MASK,
    SEL_STATUS,
    SEL_CHAN
  } reg_sel_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic [NUM_EVT-1:0] clr_vec,
  output logic [NUM_EVT-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_vec) & ~clr_vec;
  end

  // R2: every bit requested by the enable path reads back as set
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0 && clr_vec == '0) |=> ((mask_q & $past(set_vec)) == $past(set_vec)));

  // R3: every bit requested by the disable path reads back as clear
  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((mask_q & $past(clr_vec)) == '0));

  // R5: with no request the mask holds its value
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (set_vec == '0 && clr_vec == '0) |=> $stable(mask_q));
endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int unsigned NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] w1c_vec,
  output logic [NUM_EVT-1:0] stat_q
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            stat_q[i] <= 1'b0;
      else if (evt_in[i]) stat_q[i] <= 1'b1;
      else if (w1c_vec[i]) stat_q[i] <= 1'b0;
    end
  end

  // R6 / R8: an event always leaves its bit set, even under a clear
  p_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_in != '0) |=> ((stat_q & $past(evt_in)) == $past(evt_in)));

  // R7: cleared bits without a competing event read back as zero
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    ((w1c_vec & ~evt_in) != '0) |=> ((stat_q & $past(w1c_vec & ~evt_in)) == '0));

  // R6: with no event and no clear the status is stable
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_in == '0 && w1c_vec == '0) |=> $stable(stat_q));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 9,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAN_VIS = 'h1B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_EVT-1:0] mask_q,
  input  logic [NUM_EVT-1:0] stat_q,
  input  logic [NUM_EVT-1:0] lvl_in,
  output logic [DATA_W-1:0]  rd_data
);
  logic [NUM_EVT-1:0] chan_view;
  logic [DATA_W-1:0]  rd_d;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chan
    if (CHAN_VIS[i]) begin : g_vis
      assign chan_view[i] = lvl_in[i];
    end else begin : g_hid
      assign chan_view[i] = 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_MASK:   rd_d[NUM_EVT-1:0] = mask_q;
      SEL_STATUS: rd_d[NUM_EVT-1:0] = stat_q;
      SEL_CHAN:   rd_d[NUM_EVT-1:0] = chan_view;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

  // R4: the write-only registers always read back as zero
  p_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel == SEL_ENABLE || sel == SEL_DISABLE)) |=> (rd_data == '0));
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 9,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAN_VIS = 'h1B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] lvl_in,
  output logic               irq
);
  localparam int unsigned HI_W = DATA_W - NUM_EVT;

  reg_sel_e           sel;
  logic [NUM_EVT-1:0] wbits;
  logic [NUM_EVT-1:0] set_vec, clr_vec, w1c_vec;
  logic [NUM_EVT-1:0] mask_q, stat_q;
  logic               unused_hi;

  assign wbits     = wr_data[NUM_EVT-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:DATA_W-HI_W];

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_ENABLE))  sel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFF_DISABLE)) sel = SEL_DISABLE;
    else if (addr == ADDR_W'(OFF_MASK))    sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_STATUS))  sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFF_CHAN))    sel = SEL_CHAN;
  end

  assign set_vec = (wr_en && sel == SEL_ENABLE)  ? wbits : '0;
  assign clr_vec = (wr_en && sel == SEL_DISABLE) ? wbits : '0;
  assign w1c_vec = (wr_en && sel == SEL_STATUS)  ? wbits : '0;

  irq_mask_bank #(.NUM_EVT(NUM_EVT)) mask_i (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .mask_q(mask_q)
  );

  irq_sticky_status #(.NUM_EVT(NUM_EVT)) stat_i (
    .clk(clk), .rst(rst), .evt_in(evt_in), .w1c_vec(w1c_vec), .stat_q(stat_q)
  );

  irq_read_port #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .CHAN_VIS(CHAN_VIS)) rd_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .mask_q(mask_q),
    .stat_q(stat_q), .lvl_in(lvl_in), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_q & mask_q);
  end

  // R9: a pending unmasked event raises the line one cycle later
  p_irq_up_r9: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & mask_q) != '0) |=> irq);

  // R9: with nothing pending and unmasked the line drops one cycle later
  p_irq_dn_r9: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & mask_q) == '0) |=> !irq);
endmodule

// File: tb/uart_irq_bank_tb_top.sv
module uart_irq_bank_tb_top;
  localparam int unsigned NUM_EVT = 9;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic               rd_en = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [DATA_W-1:0]  rd_data;
  logic [NUM_EVT-1:0] evt_in = '0;
  logic [NUM_EVT-1:0] lvl_in = '0;
  logic               irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rd_seen = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #4 clk = ~clk;

  uart_irq_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in), .lvl_in(lvl_in),
    .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input int unsigned a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int unsigned a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic clear_with_event(input logic [DATA_W-1:0] d, input logic [NUM_EVT-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'('h14); wr_data = d; evt_in = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt_in = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq after reset");
    rd('h10, 32'h0, "R1 mask after reset");
    rd('h14, 32'h0, "R1 status after reset");

    pulse(9'h1FF);
    rd('h14, 32'h1FF, "R6 masked events latch");
    chk_irq(1'b0, "R9 no irq while masked");

    wr('h08, 32'h0A0);
    rd('h10, 32'h0A0, "R2 enable sets mask");
    wr('h08, 32'h000);
    rd('h10, 32'h0A0, "R2 zero write to enable");
    chk_irq(1'b1, "R9 irq with unmasked status");

    rd('h08, 32'h0, "R4 enable reads zero");
    rd('h0C, 32'h0, "R4 disable reads zero");

    wr('h14, 32'h0A0);
    rd('h14, 32'h15F, "R7 write-one clear");
    chk_irq(1'b0, "R9 irq drops after clear");

    wr('h0C, 32'h020);
    rd('h10, 32'h080, "R3 disable clears mask");
    wr('h0C, 32'h000);
    rd('h10, 32'h080, "R3 zero write to disable");

    wr('h10, 32'h1FF);
    rd('h10, 32'h080, "R5 mask write ignored");
    wr('h2C, 32'h1FF);
    rd('h10, 32'h080, "R5 channel write leaves mask");
    rd('h14, 32'h15F, "R5 channel write leaves status");

    clear_with_event(32'h1FF, 9'h100);
    rd('h14, 32'h100, "R8 set wins over clear");

    wr('h08, 32'hFFFF_FE00);
    rd('h10, 32'h080, "R2 high write bits ignored");

    wr('h08, 32'h100);
    chk_irq(1'b1, "R9 irq on timeout bit");

    lvl_in = 9'h1FF;
    rd('h2C, 32'h01B, "R10 channel view all set");
    lvl_in = 9'h00A;
    rd('h2C, 32'h00A, "R10 channel view pattern a");
    lvl_in = 9'h011;
    rd('h2C, 32'h011, "R10 channel view pattern b");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule